// File: doc/BRIEF.md
# Setup Packet Capture Buffer

This block holds the eight-byte setup stage of a control transfer for a USB device. The USB side pushes bytes in one at a time with a write strobe. The CPU side pulls them out one at a time through a single data location with a read strobe. A write pointer places each arriving byte. A read pointer tracks how far the CPU has drained the current setup.

The USB side always has priority. A CPU read strobe that lands in the same cycle as a USB write strobe returns a fixed invalid byte. So does a read strobe while no complete setup is held, and the read pointer does not move for either. When the first byte of a new setup arrives, the buffer drops the held setup and rewinds the read pointer. If the CPU was part-way through an eight-byte drain at that moment, a sticky overrun flag reports that the old setup was lost.

Top module: `setup_capture_buf`

## Requirements
- R1: After reset, `setup_valid`, `setup_overrun` and `capture_busy` are 0, `cpu_rd_index` is 0 and `cpu_rd_data` holds the invalid byte 0x00.
- R2: Each USB write strobe stores `usb_wr_data` at the next position, starting at position 0. `capture_busy` is 1 from the edge after the first byte until the edge of the eighth byte. `setup_valid` becomes 1 at the edge that takes the eighth byte.
- R3: A CPU read strobe while `setup_valid` is 1 and `usb_wr_en` is 0 returns the byte at `cpu_rd_index` on `cpu_rd_data` after that clock edge, and increments `cpu_rd_index`. Bytes come out in the order they were written.
- R4: The read that takes the eighth byte clears `setup_valid` and returns `cpu_rd_index` to 0.
- R5: A CPU read strobe while `setup_valid` is 0 returns 0x00 and leaves `cpu_rd_index` unchanged.
- R6: A CPU read strobe in the same cycle as a USB write strobe returns 0x00, and the USB byte is still stored.
- R7: The first byte of a capture resets `cpu_rd_index` to 0 and clears `setup_valid`. Reads during the rest of the capture return 0x00.
- R8: `setup_overrun` sets at the first byte of a capture when `cpu_rd_index` is not 0. It stays set through that capture and through any later capture that also begins with a non-zero `cpu_rd_index`. It clears only at the eighth byte of a capture that began with `cpu_rd_index` equal to 0.
- R9: After an interrupted drain, all eight bytes of the new setup can be read from position 0.
- R10: The write position wraps after eight bytes, so a ninth write strobe begins a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| usb_wr_en | input | 1 | USB side byte write strobe |
| usb_wr_data | input | DATA_W | Setup byte from the USB side |
| cpu_rd_en | input | 1 | CPU side byte read strobe |
| cpu_rd_data | output | DATA_W | Registered read result (byte or invalid value) |
| cpu_rd_index | output | $clog2(DEPTH) | Position of the next CPU read |
| setup_valid | output | 1 | A complete setup is held and not yet fully drained |
| setup_overrun | output | 1 | Sticky flag: a capture began over a partial drain |
| capture_busy | output | 1 | A capture has started and is not yet complete |

## Verification
A write pointer that is off by one shows up within one setup: `setup_valid` rises an edge early or late, and the drained bytes come out shifted against what was written. A read pointer that fails to rewind on a new capture makes the first read after that capture return a byte from the wrong position. If priority or validity gating is wrong, a read that should return 0x00 returns a real byte, or `cpu_rd_index` moves, on the very next edge. If the overrun state is wrong, `setup_overrun` shows the wrong level either at the first byte of the offending capture or at the eighth byte of the next clean one.

// File: rtl/setup_buf_pkg.sv
package setup_buf_pkg;
   // Outcome of a CPU read strobe in one cycle
   typedef enum logic [1:0] {
      RD_IDLE    = 2'd0,
      RD_DELIVER = 2'd1,
      RD_REFUSED = 2'd2
   } rd_kind_e;
endpackage

// File: rtl/setup_wr_ctrl.sv
module setup_wr_ctrl #(
   parameter int DEPTH = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   output logic [$clog2(DEPTH)-1:0] wr_idx,
   output logic                     cap_start,
   output logic                     cap_done,
   output logic                     busy
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   logic [IDX_W-1:0] wr_ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
      end else if (wr_en) begin
         if (wr_ptr_q == LAST) wr_ptr_q <= '0;
         else                  wr_ptr_q <= wr_ptr_q + 1'b1;
      end
   end

   always_comb begin
      wr_idx    = wr_ptr_q;
      cap_start = wr_en && (wr_ptr_q == '0);
      cap_done  = wr_en && (wr_ptr_q == LAST);
      busy      = (wr_ptr_q != '0);
   end
endmodule

// File: rtl/setup_store.sv
module setup_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [$clog2(DEPTH)-1:0] wr_idx,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic [DATA_W-1:0]        rd_data
);
   localparam int IDX_W = $clog2(DEPTH);

   logic [DATA_W-1:0] slot_q [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q[g] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(g))) begin
            slot_q[g] <= wr_data;
         end
      end
   end

   assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/setup_rd_ctrl.sv
module setup_rd_ctrl
   import setup_buf_pkg::*;
#(
   parameter int                DATA_W       = 8,
   parameter int                DEPTH        = 8,
   parameter logic [DATA_W-1:0] INVALID_BYTE = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_en,
   input  logic                     usb_active,
   input  logic                     cap_start,
   input  logic                     cap_done,
   input  logic [DATA_W-1:0]        store_data,
   output logic [$clog2(DEPTH)-1:0] rd_idx,
   output logic                     valid,
   output logic                     overrun,
   output logic [DATA_W-1:0]        rd_data
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   rd_kind_e         kind;
   logic [IDX_W-1:0] idx_q;
   logic             valid_q;
   logic             overrun_q;
   logic             dirty_q;    // current capture began over a partial drain
   logic [DATA_W-1:0] data_q;

   always_comb begin
      if (!rd_en)                     kind = RD_IDLE;
      else if (valid_q && !usb_active) kind = RD_DELIVER;
      else                            kind = RD_REFUSED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (cap_start) begin
         idx_q <= '0;
      end else if (kind == RD_DELIVER) begin
         if (idx_q == LAST) idx_q <= '0;
         else               idx_q <= idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else if (cap_start) begin
         valid_q <= 1'b0;
      end else if (cap_done) begin
         valid_q <= 1'b1;
      end else if ((kind == RD_DELIVER) && (idx_q == LAST)) begin
         valid_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dirty_q   <= 1'b0;
         overrun_q <= 1'b0;
      end else begin
         if (cap_start) begin
            dirty_q <= (idx_q != '0);
            if (idx_q != '0) overrun_q <= 1'b1;
         end else if (cap_done) begin
            overrun_q <= dirty_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= INVALID_BYTE;
      end else begin
         case (kind)
            RD_DELIVER: data_q <= store_data;
            RD_REFUSED: data_q <= INVALID_BYTE;
            default:    data_q <= data_q;
         endcase
      end
   end

   assign rd_idx  = idx_q;
   assign valid   = valid_q;
   assign overrun = overrun_q;
   assign rd_data = data_q;
endmodule

// File: rtl/setup_capture_buf.sv
module setup_capture_buf #(
   parameter int                DATA_W       = 8,
   parameter int                DEPTH        = 8,
   parameter logic [DATA_W-1:0] INVALID_BYTE = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     usb_wr_en,
   input  logic [DATA_W-1:0]        usb_wr_data,
   input  logic                     cpu_rd_en,
   output logic [DATA_W-1:0]        cpu_rd_data,
   output logic [$clog2(DEPTH)-1:0] cpu_rd_index,
   output logic                     setup_valid,
   output logic                     setup_overrun,
   output logic                     capture_busy
);
   localparam int IDX_W = $clog2(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("setup_capture_buf: DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("setup_capture_buf: DATA_W must be positive");
   end

   logic [IDX_W-1:0]  wr_ptr;
   logic              cap_start;
   logic              cap_done;
   logic [DATA_W-1:0] store_rd;

   setup_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (usb_wr_en),
      .wr_idx    (wr_ptr),
      .cap_start (cap_start),
      .cap_done  (cap_done),
      .busy      (capture_busy)
   );

   setup_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (usb_wr_en),
      .wr_idx  (wr_ptr),
      .wr_data (usb_wr_data),
      .rd_idx  (cpu_rd_index),
      .rd_data (store_rd)
   );

   setup_rd_ctrl #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .INVALID_BYTE(INVALID_BYTE)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (cpu_rd_en),
      .usb_active (usb_wr_en),
      .cap_start  (cap_start),
      .cap_done   (cap_done),
      .store_data (store_rd),
      .rd_idx     (cpu_rd_index),
      .valid      (setup_valid),
      .overrun    (setup_overrun),
      .rd_data    (cpu_rd_data)
   );
endmodule

// File: rtl/setup_capture_buf_chk.sv
module setup_capture_buf_chk #(
   parameter int                DATA_W       = 8,
   parameter int                DEPTH        = 8,
   parameter logic [DATA_W-1:0] INVALID_BYTE = '0
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     usb_wr_en,
   input logic                     cpu_rd_en,
   input logic [DATA_W-1:0]        cpu_rd_data,
   input logic [$clog2(DEPTH)-1:0] cpu_rd_index,
   input logic                     setup_valid,
   input logic                     setup_overrun,
   input logic [$clog2(DEPTH)-1:0] wr_idx
);
   localparam int IDX_W = $clog2(DEPTH);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   a_r2_valid_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (usb_wr_en && wr_idx == LAST) |=> setup_valid);

   a_r4_index_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd_en && setup_valid && !usb_wr_en) |=>
         (cpu_rd_index == IDX_W'($past(cpu_rd_index) + 1'b1)));

   a_r5_idle_read_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd_en && !setup_valid && !usb_wr_en) |=>
         (cpu_rd_data == INVALID_BYTE && $stable(cpu_rd_index)));

   a_r6_usb_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd_en && usb_wr_en) |=> (cpu_rd_data == INVALID_BYTE));

   a_r7_start_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
      (usb_wr_en && wr_idx == '0) |=> (cpu_rd_index == '0 && !setup_valid));

   a_r8_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (usb_wr_en && wr_idx == '0 && cpu_rd_index != '0) |=> setup_overrun);
endmodule

bind setup_capture_buf setup_capture_buf_chk #(
   .DATA_W(DATA_W), .DEPTH(DEPTH), .INVALID_BYTE(INVALID_BYTE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .usb_wr_en     (usb_wr_en),
   .cpu_rd_en     (cpu_rd_en),
   .cpu_rd_data   (cpu_rd_data),
   .cpu_rd_index  (cpu_rd_index),
   .setup_valid   (setup_valid),
   .setup_overrun (setup_overrun),
   .wr_idx        (wr_ptr)
);

// File: tb/test_setup_capture_buf.sv
`timescale 1ns/1ps
module test_setup_capture_buf;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       usb_wr_en = 1'b0;
   logic [7:0] usb_wr_data = '0;
   logic       cpu_rd_en = 1'b0;
   logic [7:0] cpu_rd_data;
   logic [2:0] cpu_rd_index;
   logic       setup_valid;
   logic       setup_overrun;
   logic       capture_busy;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   setup_capture_buf i_setup_capture_buf (
      .clk           (clk),
      .rst_n         (rst_n),
      .usb_wr_en     (usb_wr_en),
      .usb_wr_data   (usb_wr_data),
      .cpu_rd_en     (cpu_rd_en),
      .cpu_rd_data   (cpu_rd_data),
      .cpu_rd_index  (cpu_rd_index),
      .setup_valid   (setup_valid),
      .setup_overrun (setup_overrun),
      .capture_busy  (capture_busy)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr_byte(input logic [7:0] d);
      @(negedge clk);
      usb_wr_en = 1'b1; usb_wr_data = d;
      @(negedge clk);
      usb_wr_en = 1'b0;
   endtask

   task automatic rd_byte(output logic [7:0] q);
      @(negedge clk);
      cpu_rd_en = 1'b1;
      @(negedge clk);
      cpu_rd_en = 1'b0;
      q = cpu_rd_data;
   endtask

   task automatic wr_and_rd(input logic [7:0] d, output logic [7:0] q);
      @(negedge clk);
      usb_wr_en = 1'b1; usb_wr_data = d; cpu_rd_en = 1'b1;
      @(negedge clk);
      usb_wr_en = 1'b0; cpu_rd_en = 1'b0;
      q = cpu_rd_data;
   endtask

   task automatic write_setup(input logic [7:0] s [8]);
      for (int i = 0; i < 8; i++) wr_byte(s[i]);
   endtask

   task automatic drain_check(input string req, input logic [7:0] s [8]);
      logic [7:0] q;
      for (int i = 0; i < 8; i++) begin
         chk(req, "index before read", int'(cpu_rd_index), i);
         rd_byte(q);
         chk(req, "read byte", int'(q), int'(s[i]));
      end
      chk("R4", "valid after drain", int'(setup_valid), 0);
      chk("R4", "index after drain", int'(cpu_rd_index), 0);
   endtask

   task automatic t_reset();
      chk("R1", "setup_valid", int'(setup_valid), 0);
      chk("R1", "setup_overrun", int'(setup_overrun), 0);
      chk("R1", "capture_busy", int'(capture_busy), 0);
      chk("R1", "cpu_rd_index", int'(cpu_rd_index), 0);
      chk("R1", "cpu_rd_data", int'(cpu_rd_data), 0);
   endtask

   task automatic t_capture_drain();
      logic [7:0] s [8];
      for (int i = 0; i < 8; i++) s[i] = 8'(8'h10 + i * 8'h13);
      wr_byte(s[0]);
      chk("R2", "busy after first byte", int'(capture_busy), 1);
      chk("R2", "valid after first byte", int'(setup_valid), 0);
      for (int i = 1; i < 7; i++) wr_byte(s[i]);
      chk("R2", "valid before last byte", int'(setup_valid), 0);
      wr_byte(s[7]);
      chk("R2", "valid after last byte", int'(setup_valid), 1);
      chk("R2", "busy after last byte", int'(capture_busy), 0);
      drain_check("R3", s);
   endtask

   task automatic t_idle_read();
      logic [7:0] q;
      rd_byte(q);
      chk("R5", "idle read data", int'(q), 0);
      chk("R5", "idle read index", int'(cpu_rd_index), 0);
   endtask

   task automatic t_interrupted_drain();
      logic [7:0] a [8];
      logic [7:0] b [8];
      logic [7:0] c [8];
      logic [7:0] q;
      for (int i = 0; i < 8; i++) begin
         a[i] = 8'(8'hA0 + i);
         b[i] = 8'(8'hB7 - i * 3);
         c[i] = 8'(8'hC1 + i * 5);
      end
      write_setup(a);
      rd_byte(q);
      rd_byte(q);
      chk("R3", "second byte of A", int'(q), int'(a[1]));
      chk("R3", "index after two reads", int'(cpu_rd_index), 2);
      wr_and_rd(b[0], q);
      chk("R6", "read under usb write", int'(q), 0);
      chk("R7", "index rewound", int'(cpu_rd_index), 0);
      chk("R7", "valid cleared", int'(setup_valid), 0);
      chk("R8", "overrun set at start", int'(setup_overrun), 1);
      for (int i = 1; i < 4; i++) wr_byte(b[i]);
      rd_byte(q);
      chk("R7", "read during capture", int'(q), 0);
      chk("R7", "index during capture", int'(cpu_rd_index), 0);
      for (int i = 4; i < 8; i++) wr_byte(b[i]);
      chk("R8", "overrun after dirty capture", int'(setup_overrun), 1);
      chk("R2", "valid after B", int'(setup_valid), 1);
      drain_check("R9", b);
      chk("R8", "overrun after drain", int'(setup_overrun), 1);
      wr_byte(c[0]);
      chk("R8", "overrun during clean capture", int'(setup_overrun), 1);
      for (int i = 1; i < 8; i++) wr_byte(c[i]);
      chk("R8", "overrun after clean capture", int'(setup_overrun), 0);
      drain_check("R3", c);
   endtask

   task automatic t_wrap();
      logic [7:0] d [8];
      logic [7:0] e [8];
      for (int i = 0; i < 8; i++) begin
         d[i] = 8'(8'h3C ^ (i * 8'h21));
         e[i] = 8'(8'h5A + i * 7);
      end
      write_setup(d);
      chk("R10", "valid after D", int'(setup_valid), 1);
      wr_byte(e[0]);
      chk("R10", "ninth byte starts capture: valid", int'(setup_valid), 0);
      chk("R10", "ninth byte starts capture: busy", int'(capture_busy), 1);
      chk("R8", "no overrun from undrained setup", int'(setup_overrun), 0);
      for (int i = 1; i < 8; i++) wr_byte(e[i]);
      drain_check("R10", e);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_capture_drain();
      t_idle_read();
      t_interrupted_drain();
      t_wrap();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule